// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the architectural side of taking an exception in a simple in-order core. The core presents at most one already-arbitrated exception request per cycle. Each request carries its kind, a store/load flag, the faulting virtual address, the faulting program counter, a coprocessor number and a branch-delay-slot flag. In the same clock edge the block updates its system-control state: the status word, the cause word, the bad-address register, the shadow-set control word and the exception PC. One cycle later it presents the address that the fetch unit must jump to, together with a one-cycle strobe.

The handler address is not a simple function of the kind. It also depends on whether the core was already at exception level before this entry, on the boot-vector bit, and on the interrupt-vector bit. The block also holds the exception base register. A small read/write port gives the rest of the core access to every register it owns. Kinds that are recognised but not implemented raise an error strobe and leave every register as it was.

Top module: `exc_entry_ctrl`

## Requirements
- R1: An accepted request of an implemented kind produces `redirect_valid` high for exactly one cycle, in the cycle after `req_valid` is sampled. A cycle without a request produces neither `redirect_valid` nor `err_unimpl` in the next cycle.
- R2: The cause code field (cause bits [4:0]) is loaded from the request kind. `req_kind` codes: 0 interrupt→0x0, 1 TLB modified→0x1, 2 TLB refill and 3 TLB invalid→0x2 on a load and 0x3 on a store, 4 address error→0x4 on a load and 0x5 on a store, 5 system call→0x8, 6 breakpoint→0x9, 7 reserved instruction→0xA, 8 coprocessor unusable→0xB, 9 overflow→0xC, 10 trap→0xD, 11 reset.
- R3: When the boot-vector bit is clear, general exceptions redirect to ebase + 0x180.
- R4: When the boot-vector bit is clear, a TLB refill (kind 2) redirects to ebase + 0x000 if the exception-level bit was clear before the entry, and to ebase + 0x180 if it was already set.
- R5: When the boot-vector bit is clear, an interrupt redirects to ebase + 0x200 if cause bit 16 (interrupt vector) is set, and to ebase + 0x180 otherwise.
- R6: When status bit 1 (boot vector) is set, every non-reset implemented kind redirects to 0xBFC00200.
- R7: A reset request (kind 11) redirects to 0xBFC00000 and sets status bit 2 (coprocessor-1 usable). It leaves every other field unchanged.
- R8: The shadow-set word holds current set [3:0], previous set [7:4] and exception set [11:8]. On entry it is updated only if status bits 0 and 1 were both clear before entry: previous takes current, and current takes the exception set.
- R9: On each entry, cause bit 8 takes the delay-slot flag. The coprocessor field, cause bits [13:12], is cleared, except for a coprocessor-unusable entry, which loads `req_cpid` into it. Cause bit 16 is preserved.
- R10: Only address-error entries write `req_vaddr` into the bad-address register.
- R11: Each entry sets status bit 0 (exception level). It writes the exception PC with `req_pc`, or with `req_pc - 4` when `req_dslot` is set.
- R12: Kinds 12 to 15 (soft reset, NMI, thread, DSP off) pulse `err_unimpl` in the next cycle with no redirect and leave all registers unchanged.
- R13: Register port: `reg_rdata` reflects `reg_addr` combinationally. Addresses: 0 status, 1 cause, 2 bad-address, 3 shadow-set, 4 exception PC, 5 ebase. Reset values: status 0x6, ebase 0x80000000, all others 0. A write lands on the clock edge unless `req_valid` is high in that cycle, in which case the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present |
| req_kind | input | 4 | Exception kind code |
| req_store | input | 1 | Faulting access was a store |
| req_vaddr | input | 32 | Faulting virtual address |
| req_pc | input | 32 | PC of faulting instruction |
| req_cpid | input | 2 | Offending coprocessor number |
| req_dslot | input | 1 | Instruction was in a branch delay slot |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Handler address |
| err_unimpl | output | 1 | Unimplemented kind strobe |

## Verification
The bench builds the block with its default parameters: an ebase reset value of 0x80000000, offsets 0x000, 0x180 and 0x200, and the boot handler at 0xBFC00200. With these values each vector choice gives a distinct, recognisable address. An ebase rewrite to 0x90000000 shows that the offsets track the register and are not fixed. Because the exception-level and boot bits can be written through the port, the bench reaches both refill branches, the shadow-set gating in each direction, and boot-vector override from any state. It also covers a register write that collides with a request.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int DATA_W = 32;
    localparam int CODE_W = 5;
    localparam int CPID_W = 2;
    localparam int SET_W  = 4;
    localparam int SEL_W  = 3;

    typedef enum logic [3:0] {
        EK_IRQ          = 4'd0,
        EK_TLB_MOD      = 4'd1,
        EK_TLB_REFILL   = 4'd2,
        EK_TLB_INVAL    = 4'd3,
        EK_ADDR_ERR     = 4'd4,
        EK_SYSCALL      = 4'd5,
        EK_BREAK        = 4'd6,
        EK_RSVD_INSN    = 4'd7,
        EK_COP_UNUSABLE = 4'd8,
        EK_OVERFLOW     = 4'd9,
        EK_TRAP         = 4'd10,
        EK_RESET        = 4'd11,
        EK_SOFT_RESET   = 4'd12,
        EK_NMI          = 4'd13,
        EK_THREAD       = 4'd14,
        EK_DSP_OFF      = 4'd15
    } exc_kind_e;

    typedef enum logic [SEL_W-1:0] {
        CSR_STATUS  = 3'd0,
        CSR_CAUSE   = 3'd1,
        CSR_BADADDR = 3'd2,
        CSR_SHADOW  = 3'd3,
        CSR_EPC     = 3'd4,
        CSR_EBASE   = 3'd5
    } csr_sel_e;

    typedef struct packed {
        logic cu1;
        logic bev;
        logic exl;
    } status_t;

    typedef struct packed {
        logic              ivec;
        logic [CPID_W-1:0] cpe;
        logic              bd;
        logic [CODE_W-1:0] code;
    } cause_t;

    typedef struct packed {
        logic [SET_W-1:0] exc_set;
        logic [SET_W-1:0] prev_set;
        logic [SET_W-1:0] cur_set;
    } shadow_t;

    function automatic logic [CODE_W-1:0] kind_to_code(exc_kind_e k, logic st);
        logic [CODE_W-1:0] c;
        case (k)
            EK_IRQ:          c = 5'h00;
            EK_TLB_MOD:      c = 5'h01;
            EK_TLB_REFILL,
            EK_TLB_INVAL:    c = st ? 5'h03 : 5'h02;
            EK_ADDR_ERR:     c = st ? 5'h05 : 5'h04;
            EK_SYSCALL:      c = 5'h08;
            EK_BREAK:        c = 5'h09;
            EK_RSVD_INSN:    c = 5'h0A;
            EK_COP_UNUSABLE: c = 5'h0B;
            EK_OVERFLOW:     c = 5'h0C;
            EK_TRAP:         c = 5'h0D;
            default:         c = 5'h00;
        endcase
        return c;
    endfunction

    function automatic logic kind_unimpl(exc_kind_e k);
        return (k == EK_SOFT_RESET) || (k == EK_NMI) ||
               (k == EK_THREAD) || (k == EK_DSP_OFF);
    endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_pkg::*;
#(
    parameter logic [DATA_W-1:0] OFS_REFILL   = 32'h0000_0000,
    parameter logic [DATA_W-1:0] OFS_GENERAL  = 32'h0000_0180,
    parameter logic [DATA_W-1:0] OFS_IRQ      = 32'h0000_0200,
    parameter logic [DATA_W-1:0] BOOT_HANDLER = 32'hBFC0_0200,
    parameter logic [DATA_W-1:0] RESET_VECTOR = 32'hBFC0_0000
) (
    input  exc_kind_e         kind,
    input  logic              exl_before,
    input  logic              bev,
    input  logic              ivec,
    input  logic [DATA_W-1:0] ebase,
    output logic [DATA_W-1:0] handler
);
    always_comb begin
        if (kind == EK_RESET)
            handler = RESET_VECTOR;
        else if (bev)
            handler = BOOT_HANDLER;
        else if (kind == EK_TLB_REFILL && !exl_before)
            handler = ebase + OFS_REFILL;
        else if (kind == EK_IRQ && ivec)
            handler = ebase + OFS_IRQ;
        else
            handler = ebase + OFS_GENERAL;
    end
endmodule

// File: rtl/exc_cause_gen.sv
module exc_cause_gen
    import exc_pkg::*;
(
    input  exc_kind_e         kind,
    input  logic              store,
    input  logic [CPID_W-1:0] cpid,
    input  logic              dslot,
    input  cause_t            cause_in,
    output cause_t            cause_out
);
    always_comb begin
        cause_out      = cause_in;
        cause_out.code = kind_to_code(kind, store);
        cause_out.bd   = dslot;
        cause_out.cpe  = (kind == EK_COP_UNUSABLE) ? cpid : '0;
    end
endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
    import exc_pkg::*;
#(
    parameter logic [DATA_W-1:0] EBASE_RESET = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              ent_en,
    input  logic              boot_en,
    input  cause_t            ent_cause,
    input  logic [DATA_W-1:0] ent_epc,
    input  logic              bad_en,
    input  logic [DATA_W-1:0] bad_val,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output status_t           status_q,
    output cause_t            cause_q,
    output shadow_t           shadow_q,
    output logic [DATA_W-1:0] bad_q,
    output logic [DATA_W-1:0] epc_q,
    output logic [DATA_W-1:0] ebase_q
);
    localparam int ST_W = $bits(status_t);
    localparam int CA_W = $bits(cause_t);
    localparam int SH_W = $bits(shadow_t);
    localparam int IV_POS = 16;
    localparam int CP_POS = 12;
    localparam int BD_POS = 8;

    logic wr_ok;
    assign wr_ok = reg_we && !busy;

    logic [DATA_W-1:0] cause_word;
    always_comb begin
        cause_word = '0;
        cause_word[CODE_W-1:0]           = cause_q.code;
        cause_word[BD_POS]               = cause_q.bd;
        cause_word[CP_POS +: CPID_W]     = cause_q.cpe;
        cause_word[IV_POS]               = cause_q.ivec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '{cu1: 1'b1, bev: 1'b1, exl: 1'b0};
            cause_q  <= '0;
            shadow_q <= '0;
            bad_q    <= '0;
            epc_q    <= '0;
            ebase_q  <= EBASE_RESET;
        end else if (ent_en) begin
            status_q.exl <= 1'b1;
            cause_q      <= ent_cause;
            epc_q        <= ent_epc;
            if (bad_en)
                bad_q <= bad_val;
            if (!status_q.exl && !status_q.bev) begin
                shadow_q.prev_set <= shadow_q.cur_set;
                shadow_q.cur_set  <= shadow_q.exc_set;
            end
        end else if (boot_en) begin
            status_q.cu1 <= 1'b1;
        end else if (wr_ok) begin
            case (csr_sel_e'(reg_addr))
                CSR_STATUS:  status_q <= status_t'(reg_wdata[ST_W-1:0]);
                CSR_CAUSE: begin
                    cause_q.code <= reg_wdata[CODE_W-1:0];
                    cause_q.bd   <= reg_wdata[BD_POS];
                    cause_q.cpe  <= reg_wdata[CP_POS +: CPID_W];
                    cause_q.ivec <= reg_wdata[IV_POS];
                end
                CSR_BADADDR: bad_q    <= reg_wdata;
                CSR_SHADOW:  shadow_q <= shadow_t'(reg_wdata[SH_W-1:0]);
                CSR_EPC:     epc_q    <= reg_wdata;
                CSR_EBASE:   ebase_q  <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (csr_sel_e'(reg_addr))
            CSR_STATUS:  reg_rdata[ST_W-1:0] = status_q;
            CSR_CAUSE:   reg_rdata = cause_word;
            CSR_BADADDR: reg_rdata = bad_q;
            CSR_SHADOW:  reg_rdata[SH_W-1:0] = shadow_q;
            CSR_EPC:     reg_rdata = epc_q;
            CSR_EBASE:   reg_rdata = ebase_q;
            default:     reg_rdata = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^{CA_W[0]};
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter logic [DATA_W-1:0] EBASE_RESET  = 32'h8000_0000,
    parameter logic [DATA_W-1:0] OFS_REFILL   = 32'h0000_0000,
    parameter logic [DATA_W-1:0] OFS_GENERAL  = 32'h0000_0180,
    parameter logic [DATA_W-1:0] OFS_IRQ      = 32'h0000_0200,
    parameter logic [DATA_W-1:0] BOOT_HANDLER = 32'hBFC0_0200,
    parameter logic [DATA_W-1:0] RESET_VECTOR = 32'hBFC0_0000,
    parameter logic [DATA_W-1:0] INSN_BYTES   = 32'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic              req_store,
    input  logic [31:0]       req_vaddr,
    input  logic [31:0]       req_pc,
    input  logic [1:0]        req_cpid,
    input  logic              req_dslot,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc,
    output logic              err_unimpl
);
    exc_kind_e kind;
    assign kind = exc_kind_e'(req_kind);

    status_t           status_q;
    cause_t            cause_q;
    cause_t            cause_nx;
    shadow_t           shadow_q;
    logic [DATA_W-1:0] bad_q, epc_q, ebase_q;
    logic [DATA_W-1:0] handler;
    logic [DATA_W-1:0] epc_nx;
    logic              unimpl, ent_en, boot_en, bad_en;

    assign unimpl  = kind_unimpl(kind);
    assign ent_en  = req_valid && !unimpl && (kind != EK_RESET);
    assign boot_en = req_valid && (kind == EK_RESET);
    assign bad_en  = (kind == EK_ADDR_ERR);
    assign epc_nx  = req_dslot ? (req_pc - INSN_BYTES) : req_pc;

    exc_vector_sel #(
        .OFS_REFILL   (OFS_REFILL),
        .OFS_GENERAL  (OFS_GENERAL),
        .OFS_IRQ      (OFS_IRQ),
        .BOOT_HANDLER (BOOT_HANDLER),
        .RESET_VECTOR (RESET_VECTOR)
    ) u_vec (
        .kind       (kind),
        .exl_before (status_q.exl),
        .bev        (status_q.bev),
        .ivec       (cause_q.ivec),
        .ebase      (ebase_q),
        .handler    (handler)
    );

    exc_cause_gen u_cause (
        .kind      (kind),
        .store     (req_store),
        .cpid      (req_cpid),
        .dslot     (req_dslot),
        .cause_in  (cause_q),
        .cause_out (cause_nx)
    );

    exc_csr_bank #(
        .EBASE_RESET (EBASE_RESET)
    ) u_csr (
        .clk       (clk),
        .rst       (rst),
        .busy      (req_valid),
        .ent_en    (ent_en),
        .boot_en   (boot_en),
        .ent_cause (cause_nx),
        .ent_epc   (epc_nx),
        .bad_en    (bad_en),
        .bad_val   (req_vaddr),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .status_q  (status_q),
        .cause_q   (cause_q),
        .shadow_q  (shadow_q),
        .bad_q     (bad_q),
        .epc_q     (epc_q),
        .ebase_q   (ebase_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            err_unimpl     <= 1'b0;
        end else begin
            redirect_valid <= req_valid && !unimpl;
            err_unimpl     <= req_valid && unimpl;
            if (req_valid && !unimpl)
                redirect_pc <= handler;
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter logic [DATA_W-1:0] BOOT_HANDLER = 32'hBFC0_0200
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [3:0]        req_kind,
    input logic              redirect_valid,
    input logic [31:0]       redirect_pc,
    input logic              err_unimpl,
    input status_t           status_q,
    input logic [DATA_W-1:0] ebase_q,
    input logic [DATA_W-1:0] epc_q
);
    logic impl_req, norm_req;
    assign impl_req = req_valid && !kind_unimpl(exc_kind_e'(req_kind));
    assign norm_req = impl_req && (exc_kind_e'(req_kind) != EK_RESET);

    a_r1_strobe: assert property (@(posedge clk) disable iff (rst)
        impl_req |=> redirect_valid);

    a_r1_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!redirect_valid && !err_unimpl));

    a_r4_refill_base: assert property (@(posedge clk) disable iff (rst)
        (req_valid && exc_kind_e'(req_kind) == EK_TLB_REFILL && !status_q.exl && !status_q.bev)
        |=> redirect_pc == $past(ebase_q));

    a_r6_boot_vector: assert property (@(posedge clk) disable iff (rst)
        (norm_req && status_q.bev) |=> redirect_pc == BOOT_HANDLER);

    a_r11_exl_set: assert property (@(posedge clk) disable iff (rst)
        norm_req |=> status_q.exl);

    a_r12_unimpl: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind_unimpl(exc_kind_e'(req_kind)))
        |=> (err_unimpl && !redirect_valid && $stable(epc_q) && $stable(status_q)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.BOOT_HANDLER(BOOT_HANDLER)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_kind       (req_kind),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .err_unimpl     (err_unimpl),
    .status_q       (status_q),
    .ebase_q        (ebase_q),
    .epc_q          (epc_q)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = '0;
    logic        req_store = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_pc = '0;
    logic [1:0]  req_cpid = '0;
    logic        req_dslot = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        err_unimpl;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    bit done    = 0;

    logic [32:0] expq[$];

    always #2 clk = ~clk;

    exc_entry_ctrl u0 (.*);

    task automatic report();
        if (!done) begin
            done = 1;
            if (expq.size() != 0) begin
                misses++;
                $display("FAIL R1: %0d expected redirects never seen, expected 0", expq.size());
            end
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            misses++;
            $display("FAIL watchdog: cycles %0d, expected under 20000", cycles);
            report();
        end
    end

    // monitor: pops expected results as outputs appear
    always @(negedge clk) begin
        if (!rst && (redirect_valid || err_unimpl)) begin
            logic [32:0] e;
            vectors++;
            if (expq.size() == 0) begin
                misses++;
                $display("FAIL R1: unexpected output valid=%0b err=%0b, expected none",
                         redirect_valid, err_unimpl);
            end else begin
                e = expq.pop_front();
                if (e[32]) begin
                    if (!err_unimpl || redirect_valid) begin
                        misses++;
                        $display("FAIL R12: err=%0b valid=%0b, expected err=1 valid=0",
                                 err_unimpl, redirect_valid);
                    end
                end else if (err_unimpl || redirect_pc !== e[31:0]) begin
                    misses++;
                    $display("FAIL R3-6: pc=%h err=%0b, expected pc=%h err=0",
                             redirect_pc, err_unimpl, e[31:0]);
                end
            end
        end
    end

    task automatic fire(input logic [3:0] k, input logic st, input logic [31:0] va,
                        input logic [31:0] pc, input logic [1:0] cp, input logic ds,
                        input logic exp_err, input logic [31:0] exp_pc, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_store = st; req_vaddr = va;
        req_pc = pc; req_cpid = cp; req_dslot = ds;
        if (wr) begin
            reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h1234_5000;
        end
        expq.push_back({exp_err, exp_pc});
        @(negedge clk);
        req_valid = 1'b0; reg_we = 1'b0;
        @(negedge clk);
        if (redirect_valid || err_unimpl) begin
            misses++;
            $display("FAIL R1: strobe held valid=%0b err=%0b, expected 0", redirect_valid, err_unimpl);
        end
        vectors++;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        vectors++;
        if (reg_rdata !== exp) begin
            misses++;
            $display("FAIL %s: reg %0d = %h, expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset values
        rd(0, 32'h6, "R13"); rd(1, 32'h0, "R13"); rd(2, 32'h0, "R13");
        rd(3, 32'h0, "R13"); rd(4, 32'h0, "R13"); rd(5, 32'h8000_0000, "R13");
        // R6 boot vector after reset; R8 no shadow update with bev set
        fire(5, 0, 0, 32'h400, 0, 0, 0, 32'hBFC0_0200, 0);
        rd(0, 32'h7, "R11"); rd(1, 32'h08, "R2"); rd(4, 32'h400, "R11"); rd(3, 32'h0, "R8");
        wr(0, 32'h0); wr(3, 32'h502);
        // R3 general, R9 delay slot, R8 shadow update
        fire(6, 0, 0, 32'h1000, 0, 1, 0, 32'h8000_0180, 0);
        rd(4, 32'hFFC, "R11"); rd(1, 32'h109, "R9"); rd(3, 32'h525, "R8"); rd(0, 32'h1, "R11");
        // R4 refill while exl set
        fire(2, 0, 0, 32'h1100, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h002, "R2"); rd(3, 32'h525, "R8");
        wr(0, 32'h0);
        // R4 refill with exl clear, store
        fire(2, 1, 0, 32'h1200, 0, 0, 0, 32'h8000_0000, 0);
        rd(1, 32'h003, "R2"); rd(3, 32'h555, "R8");
        // R5 interrupts
        fire(0, 0, 0, 32'h1300, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h0, "R2");
        wr(1, 32'h1_0000);
        fire(0, 0, 0, 32'h1304, 0, 0, 0, 32'h8000_0200, 0);
        rd(1, 32'h1_0000, "R5");
        // R10 address errors
        fire(4, 1, 32'hDEAD_0001, 32'h1400, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h1_0005, "R2"); rd(2, 32'hDEAD_0001, "R10");
        fire(4, 0, 32'h1234, 32'h1404, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h1_0004, "R2"); rd(2, 32'h1234, "R10");
        fire(9, 0, 32'h5555, 32'h1408, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h1_000C, "R2"); rd(2, 32'h1234, "R10");
        // R9 coprocessor id
        fire(8, 0, 0, 32'h2000, 3, 1, 0, 32'h8000_0180, 0);
        rd(1, 32'h1_310B, "R9"); rd(4, 32'h1FFC, "R11");
        fire(10, 0, 0, 32'h2004, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h1_000D, "R9");
        fire(7, 0, 0, 32'h2008, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h1_000A, "R2");
        fire(1, 0, 0, 32'h200C, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h1_0001, "R2");
        fire(3, 1, 0, 32'h2010, 0, 0, 0, 32'h8000_0180, 0);
        rd(1, 32'h1_0003, "R2");
        // R3 tracks ebase
        wr(5, 32'h9000_0000);
        fire(5, 0, 0, 32'h3000, 0, 0, 0, 32'h9000_0180, 0);
        rd(1, 32'h1_0008, "R2");
        // R12 unimplemented kinds
        fire(13, 1, 32'hFFFF_0000, 32'h7000, 2, 1, 1, 32'h0, 0);
        rd(4, 32'h3000, "R12"); rd(1, 32'h1_0008, "R12"); rd(2, 32'h1234, "R12");
        fire(14, 0, 0, 32'h7004, 0, 0, 1, 32'h0, 1);
        rd(5, 32'h9000_0000, "R13");
        fire(12, 0, 0, 32'h7008, 0, 0, 1, 32'h0, 0);
        fire(15, 0, 0, 32'h700C, 0, 0, 1, 32'h0, 0);
        rd(0, 32'h1, "R12");
        // R13 write dropped under a request
        fire(5, 0, 0, 32'h3100, 0, 0, 0, 32'h9000_0180, 1);
        rd(5, 32'h9000_0000, "R13"); rd(4, 32'h3100, "R11");
        // R7 reset kind
        wr(0, 32'h0);
        fire(11, 0, 0, 32'h3200, 0, 1, 0, 32'hBFC0_0000, 0);
        rd(0, 32'h4, "R7"); rd(4, 32'h3100, "R7"); rd(1, 32'h1_0008, "R7");
        // R6 boot bit overrides refill base
        wr(0, 32'h2);
        fire(2, 0, 0, 32'h3300, 0, 0, 0, 32'hBFC0_0200, 0);
        rd(3, 32'h555, "R8");
        repeat (3) @(negedge clk);
        report();
    end
endmodule